// File: doc/BRIEF.md
# Serial Memory Pause-Pin Front End

This block sits at the pin edge of a serial memory slave. It watches the chip select, serial clock, data input and an active-low pause (hold) input. It turns them into a qualified shift strobe with its sampled data bit, a position-in-byte count, a data-output enable, a pause status flag and a one-cycle interface reset for the downstream command decoder. Every pin is oversampled by a fast system clock through a two-stage synchronizer. All serial-clock edges are therefore seen as synchronous events. The system clock must run at least four times the serial clock rate.

A pause may only begin while the device is selected. Pause entry and exit both follow the serial clock level. When the pause pin changes while the serial clock is low, the change takes effect at once. When it changes while the serial clock is high, the change waits until the serial clock next falls. During a pause the serial clock and data input are ignored, and the output driver is released.

Releasing chip select during a pause resets the interface. The block then refuses traffic until the pause pin has been seen high while deselected, and chip select is lowered again after that. A busy flag from the program and erase engines passes through one register, and pausing never affects it.

The controller has six states:
- `ST_IDLE`: deselected.
- `ST_ACTIVE`: selected and shifting.
- `ST_ENTER_WAIT`: the pause pin fell while the serial clock was high.
- `ST_PAUSED`: the pause is in effect.
- `ST_EXIT_WAIT`: the pause pin rose while the serial clock was high.
- `ST_LOCKOUT`: the interface was reset by a deselect during a pause.

The transitions are:
- IDLE→ACTIVE when select goes low.
- ACTIVE→IDLE and ENTER_WAIT→IDLE when select goes high.
- ACTIVE→PAUSED when the pause pin is low and the clock is low.
- ACTIVE→ENTER_WAIT when the pause pin is low and the clock is high.
- ENTER_WAIT→PAUSED when the clock falls.
- ENTER_WAIT→ACTIVE when the pause pin returns high.
- PAUSED→ACTIVE when the pause pin is high and the clock is low.
- PAUSED→EXIT_WAIT when the pause pin is high and the clock is high.
- EXIT_WAIT→ACTIVE when the clock falls.
- EXIT_WAIT→PAUSED when the pause pin drops again.
- PAUSED→LOCKOUT and EXIT_WAIT→LOCKOUT when select goes high.
- LOCKOUT→IDLE when the pause pin is high and select is high.

Top module: `sflash_pause_front`

## Requirements
- R1: After reset, `shift_en`, `sdo_oe`, `pause_active` and `iface_reset` are 0 and `bit_pos` is 0.
- R2: While selected and not paused, each rising edge of `sck_pin` gives exactly one `shift_en` pulse, and `shift_bit` carries the `sdi_pin` level sampled at that edge.
- R3: `bit_pos` counts `shift_en` pulses modulo BYTE_W and returns to 0 whenever chip select is high.
- R4: If `hold_n_pin` falls while selected with `sck_pin` low, `pause_active` becomes 1 within six system clocks.
- R5: If `hold_n_pin` falls while `sck_pin` is high, `pause_active` stays 0 until `sck_pin` falls, and then becomes 1.
- R6: If `hold_n_pin` rises with `sck_pin` low, the pause ends at once. If it rises with `sck_pin` high, `pause_active` stays 1 until `sck_pin` falls.
- R7: While `pause_active` is 1, `sck_pin` and `sdi_pin` are ignored: no `shift_en` pulse occurs and `bit_pos` does not change.
- R8: `sdo_oe` is 1 only when selected, not paused, not locked out and `read_phase` is 1. Otherwise it is 0.
- R9: `hold_n_pin` has no effect while chip select is high: `pause_active` stays 0.
- R10: Raising chip select during a pause gives exactly one single-cycle `iface_reset` pulse, clears `bit_pos` and drops `pause_active`.
- R11: After an R10 reset, lowering chip select while `hold_n_pin` is still low gives no `shift_en`, no `sdo_oe` and no pause. Traffic resumes only after `hold_n_pin` is seen high while deselected and chip select is then lowered.
- R12: `busy_out` equals `busy_in` delayed by one system clock, whatever the state of chip select or the pause pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n_pin | input | 1 | Chip select pin, active low, asynchronous |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| sdi_pin | input | 1 | Serial data input pin, asynchronous |
| hold_n_pin | input | 1 | Pause pin, active low, asynchronous |
| read_phase | input | 1 | From the decoder: output data phase in progress |
| busy_in | input | 1 | Busy flag from the program/erase engines |
| shift_en | output | 1 | One-cycle strobe per accepted serial clock rise |
| shift_bit | output | 1 | Data bit sampled with the latest strobe |
| bit_pos | output | $clog2(BYTE_W) | Bit position within the current byte |
| sdo_oe | output | 1 | Data-output driver enable (0 = high impedance) |
| pause_active | output | 1 | Pause condition in effect |
| iface_reset | output | 1 | One-cycle reset pulse for the command decoder |
| busy_out | output | 1 | Busy flag passed through, unaffected by pause |

## Verification
The assertions assume the following about the inputs:
- Pin levels stay stable long enough for the two-stage synchronizer to settle. Each serial-clock phase lasts at least four system clocks.
- `busy_in` and `read_phase` are already synchronous to `clk`.

The stimulus keeps within these limits. Each serial-clock half period is eight system clocks. Pause, select and data changes are made only at system-clock falling edges. Each is followed by at least six idle clocks before outputs are sampled. Random bit streams with random pauses are mixed with directed runs of pause entry and exit under both serial-clock levels, a deselect during a pause, and the re-entry ordering that follows it.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ACTIVE     = 3'd1,
        ST_ENTER_WAIT = 3'd2,
        ST_PAUSED     = 3'd3,
        ST_EXIT_WAIT  = 3'd4,
        ST_LOCKOUT    = 3'd5
    } pause_state_t;

    // Bit positions of the pins inside the synchronizer bundle
    localparam int PIN_CS    = 0;
    localparam int PIN_SCK   = 1;
    localparam int PIN_SDI   = 2;
    localparam int PIN_HOLD  = 3;
    localparam int PIN_COUNT = 4;

    // Idle level of each pin: select high, clock low, data low, pause pin high
    localparam logic [PIN_COUNT-1:0] PIN_IDLE = 4'b1001;

endpackage

// File: rtl/sfp_pin_sync.sv
module sfp_pin_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] lvl
);

    // One independent flop chain per pin
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[i]}};
            end else begin
                chain <= {chain[STAGES-2:0], pin[i]};
            end
        end

        assign lvl[i] = chain[STAGES-1];
    end

    initial begin
        assert (STAGES >= 2) else $error("sfp_pin_sync needs at least two stages");
    end

endmodule

// File: rtl/sfp_pause_fsm.sv
module sfp_pause_fsm
    import sfp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_hi,
    input  logic sck_hi,
    input  logic sdi_lvl,
    input  logic hold_hi,
    input  logic read_phase,
    output logic pause_active,
    output logic shift_en,
    output logic shift_bit,
    output logic sdo_oe,
    output logic iface_reset
);

    pause_state_t state_q, state_d;
    logic         sck_prev;
    logic         sck_rise;
    logic         paused;
    logic         running;

    // State register and serial-clock edge memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sck_prev <= 1'b0;
        end else begin
            state_q  <= state_d;
            sck_prev <= sck_hi;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_hi) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (cs_hi)             state_d = ST_IDLE;
                else if (!hold_hi && !sck_hi) state_d = ST_PAUSED;
                else if (!hold_hi)     state_d = ST_ENTER_WAIT;
            end
            ST_ENTER_WAIT: begin
                if (cs_hi)        state_d = ST_IDLE;
                else if (hold_hi) state_d = ST_ACTIVE;
                else if (!sck_hi) state_d = ST_PAUSED;
            end
            ST_PAUSED: begin
                if (cs_hi)                   state_d = ST_LOCKOUT;
                else if (hold_hi && !sck_hi) state_d = ST_ACTIVE;
                else if (hold_hi)            state_d = ST_EXIT_WAIT;
            end
            ST_EXIT_WAIT: begin
                if (cs_hi)         state_d = ST_LOCKOUT;
                else if (!hold_hi) state_d = ST_PAUSED;
                else if (!sck_hi)  state_d = ST_ACTIVE;
            end
            ST_LOCKOUT: begin
                if (hold_hi && cs_hi) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign sck_rise = sck_hi && !sck_prev;
    assign paused   = (state_q == ST_PAUSED) || (state_q == ST_EXIT_WAIT);
    assign running  = ((state_q == ST_ACTIVE) || (state_q == ST_ENTER_WAIT)) && !cs_hi;

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_active <= 1'b0;
            shift_en     <= 1'b0;
            shift_bit    <= 1'b0;
            sdo_oe       <= 1'b0;
            iface_reset  <= 1'b0;
        end else begin
            pause_active <= paused;
            shift_en     <= running && sck_rise;
            if (running && sck_rise) shift_bit <= sdi_lvl;
            sdo_oe       <= running && read_phase;
            iface_reset  <= paused && cs_hi;
        end
    end

    // A pause can only start from a selected state
    assert_enter_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSED) && ($past(state_q) != ST_PAUSED) && ($past(state_q) != ST_EXIT_WAIT)
            |-> !$past(cs_hi));

    // Lockout leaves only to idle, and only after the pause pin is high while deselected
    assert_lockout_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_LOCKOUT) && (state_q != ST_LOCKOUT)
            |-> (state_q == ST_IDLE) && $past(hold_hi) && $past(cs_hi));

    // Deferred entry: the wait state resolves into a pause only once the clock is low
    assert_deferred_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_ENTER_WAIT) && (state_q == ST_PAUSED) |-> !$past(sck_hi));

    // Deferred exit: the exit wait returns to active only once the clock is low
    assert_deferred_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_EXIT_WAIT) && (state_q == ST_ACTIVE) |-> !$past(sck_hi));

endmodule

// File: rtl/sfp_bit_pos.sv
module sfp_bit_pos #(
    parameter int BYTE_W = 8,
    localparam int PW    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          clear,
    output logic [PW-1:0] pos
);

    localparam logic [PW-1:0] LAST = PW'(BYTE_W - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pos <= '0;
        end else if (step) begin
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
        end
    end

    // The position only moves on an accepted strobe
    assert_pos_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(step) && !$past(clear) |-> $stable(pos));

    // The position never reaches BYTE_W
    assert_pos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST);

endmodule

// File: rtl/sflash_pause_front.sv
module sflash_pause_front #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n_pin,
    input  logic                        sck_pin,
    input  logic                        sdi_pin,
    input  logic                        hold_n_pin,
    input  logic                        read_phase,
    input  logic                        busy_in,
    output logic                        shift_en,
    output logic                        shift_bit,
    output logic [$clog2(BYTE_W)-1:0]   bit_pos,
    output logic                        sdo_oe,
    output logic                        pause_active,
    output logic                        iface_reset,
    output logic                        busy_out
);
    import sfp_pkg::*;

    logic [PIN_COUNT-1:0] pins_raw;
    logic [PIN_COUNT-1:0] pins_lvl;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_CS]   = cs_n_pin;
        pins_raw[PIN_SCK]  = sck_pin;
        pins_raw[PIN_SDI]  = sdi_pin;
        pins_raw[PIN_HOLD] = hold_n_pin;
    end

    sfp_pin_sync #(
        .W       (PIN_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pins_raw),
        .lvl   (pins_lvl)
    );

    sfp_pause_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_hi        (pins_lvl[PIN_CS]),
        .sck_hi       (pins_lvl[PIN_SCK]),
        .sdi_lvl      (pins_lvl[PIN_SDI]),
        .hold_hi      (pins_lvl[PIN_HOLD]),
        .read_phase   (read_phase),
        .pause_active (pause_active),
        .shift_en     (shift_en),
        .shift_bit    (shift_bit),
        .sdo_oe       (sdo_oe),
        .iface_reset  (iface_reset)
    );

    sfp_bit_pos #(
        .BYTE_W (BYTE_W)
    ) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (shift_en),
        .clear (iface_reset || pins_lvl[PIN_CS]),
        .pos   (bit_pos)
    );

    // Busy flag passes through untouched by pause or select
    always_ff @(posedge clk) begin
        if (!rst_n) busy_out <= 1'b0;
        else        busy_out <= busy_in;
    end

    assert_no_shift_in_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pause_active |-> !shift_en);

    assert_oe_off_in_pause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pause_active |-> !sdo_oe);

    assert_reset_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        iface_reset |=> !iface_reset);

    assert_busy_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (busy_out == $past(busy_in)));

endmodule

// File: tb/sim_sflash_pause_front.sv
`timescale 1ns/1ps
module sim_sflash_pause_front;

    localparam int BYTE_W = 8;
    localparam int PW     = $clog2(BYTE_W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1;
    logic read_phase = 1'b0, busy_in = 1'b0;
    logic shift_en, shift_bit, sdo_oe, pause_active, iface_reset, busy_out;
    logic [PW-1:0] bit_pos;

    int n_checks = 0;
    int n_fail   = 0;
    int n_shift  = 0;
    int n_rst    = 0;
    logic [31:0] cap = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sflash_pause_front #(.BYTE_W(BYTE_W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_pin     (cs_n),
        .sck_pin      (sck),
        .sdi_pin      (sdi),
        .hold_n_pin   (hold_n),
        .read_phase   (read_phase),
        .busy_in      (busy_in),
        .shift_en     (shift_en),
        .shift_bit    (shift_bit),
        .bit_pos      (bit_pos),
        .sdo_oe       (sdo_oe),
        .pause_active (pause_active),
        .iface_reset  (iface_reset),
        .busy_out     (busy_out)
    );

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && shift_en) begin
            n_shift <= n_shift + 1;
            cap     <= {cap[30:0], shift_bit};
        end
        if (rst_n && iface_reset) n_rst <= n_rst + 1;
    end

    function automatic int exp_pos(input int nbits);
        return nbits % BYTE_W;
    endfunction

    function automatic logic [31:0] low_mask(input int nbits);
        return (nbits >= 32) ? 32'hFFFF_FFFF : ((32'd1 << nbits) - 32'd1);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sck_bit(input logic b);
        sdi = b;
        tick(8);
        sck = 1'b1;
        tick(8);
        sck = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        int k;
        logic [31:0] exp_bits;
        logic b;
        void'($urandom(32'd5081));

        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        check_eq("R1 shift_en", int'(shift_en), 0);
        check_eq("R1 sdo_oe", int'(sdo_oe), 0);
        check_eq("R1 pause_active", int'(pause_active), 0);
        check_eq("R1 iface_reset", int'(iface_reset), 0);
        check_eq("R1 bit_pos", int'(bit_pos), 0);

        // R9 pause pin ignored while deselected
        hold_n = 1'b0;
        tick(10);
        check_eq("R9 pause while deselected", int'(pause_active), 0);
        base = n_shift;
        sck_bit(1'b1);
        tick(6);
        check_eq("R9 no shift while deselected", n_shift - base, 0);
        hold_n = 1'b1;
        tick(6);

        // R8 output enable
        cs_n = 1'b0;
        read_phase = 1'b1;
        tick(6);
        check_eq("R8 oe selected read", int'(sdo_oe), 1);
        read_phase = 1'b0;
        tick(3);
        check_eq("R8 oe no read phase", int'(sdo_oe), 0);
        read_phase = 1'b1;
        // R4 immediate pause entry with clock low
        hold_n = 1'b0;
        tick(6);
        check_eq("R4 pause with sck low", int'(pause_active), 1);
        check_eq("R8 oe off in pause", int'(sdo_oe), 0);
        // R12 busy passes through during pause
        busy_in = 1'b1;
        tick(1);
        check_eq("R12 busy rise", int'(busy_out), 1);
        busy_in = 1'b0;
        tick(1);
        check_eq("R12 busy fall", int'(busy_out), 0);
        // R6 immediate exit with clock low
        hold_n = 1'b1;
        tick(6);
        check_eq("R6 exit with sck low", int'(pause_active), 0);
        check_eq("R8 oe back after pause", int'(sdo_oe), 1);
        cs_n = 1'b1;
        tick(6);
        check_eq("R8 oe deselected", int'(sdo_oe), 0);
        read_phase = 1'b0;

        // R5 deferred entry, R6 deferred exit
        cs_n = 1'b0;
        tick(6);
        base = n_shift;
        sck = 1'b1;
        tick(6);
        hold_n = 1'b0;
        tick(10);
        check_eq("R5 no pause while sck high", int'(pause_active), 0);
        sck = 1'b0;
        tick(6);
        check_eq("R5 pause after sck falls", int'(pause_active), 1);
        sck = 1'b1;
        tick(6);
        hold_n = 1'b1;
        tick(10);
        check_eq("R6 pause held while sck high", int'(pause_active), 1);
        sck = 1'b0;
        tick(6);
        check_eq("R6 pause ends after sck falls", int'(pause_active), 0);
        check_eq("R7 rise during pause ignored", n_shift - base, 1);
        check_eq("R3 position after one bit", int'(bit_pos), 1);
        cs_n = 1'b1;
        tick(6);
        check_eq("R3 position cleared by deselect", int'(bit_pos), 0);

        // R10 deselect during pause
        cs_n = 1'b0;
        tick(6);
        sck_bit(1'b1);
        sck_bit(1'b0);
        tick(6);
        check_eq("R3 position after two bits", int'(bit_pos), 2);
        hold_n = 1'b0;
        tick(6);
        base = n_rst;
        cs_n = 1'b1;
        tick(8);
        check_eq("R10 one reset pulse", n_rst - base, 1);
        check_eq("R10 position cleared", int'(bit_pos), 0);
        check_eq("R10 pause dropped", int'(pause_active), 0);

        // R11 re-entry guard
        cs_n = 1'b0;
        read_phase = 1'b1;
        tick(6);
        base = n_shift;
        sck_bit(1'b1);
        sck_bit(1'b1);
        sck_bit(1'b0);
        tick(6);
        check_eq("R11 no shift in lockout", n_shift - base, 0);
        check_eq("R11 no pause in lockout", int'(pause_active), 0);
        check_eq("R11 no oe in lockout", int'(sdo_oe), 0);
        hold_n = 1'b1;
        tick(6);
        base = n_shift;
        sck_bit(1'b1);
        tick(6);
        check_eq("R11 still locked while selected", n_shift - base, 0);
        cs_n = 1'b1;
        read_phase = 1'b0;
        tick(6);
        cs_n = 1'b0;
        tick(6);
        base = n_shift;
        sck_bit(1'b1);
        sck_bit(1'b0);
        sck_bit(1'b1);
        tick(6);
        check_eq("R11 traffic resumes", n_shift - base, 3);
        check_eq("R2 resumed bits", int'(cap[2:0]), 5);
        cs_n = 1'b1;
        tick(6);

        // Random streams with random pauses (R2, R3, R7)
        for (int t = 0; t < 10; t++) begin
            cs_n = 1'b0;
            tick(6);
            base = n_shift;
            k = 1 + int'($urandom % 20);
            exp_bits = '0;
            for (int i = 0; i < k; i++) begin
                b = logic'($urandom % 2);
                exp_bits = {exp_bits[30:0], b};
                sck_bit(b);
                if ($urandom % 3 == 0) begin
                    hold_n = 1'b0;
                    tick(6 + int'($urandom % 10));
                    if ($urandom % 2 == 1) sck_bit(logic'($urandom % 2));
                    hold_n = 1'b1;
                    tick(6);
                end
            end
            tick(6);
            check_eq("R2 random shift count", n_shift - base, k);
            check_eq("R2 random shifted bits", int'(cap & low_mask(k)), int'(exp_bits & low_mask(k)));
            check_eq("R7 random position", int'(bit_pos), exp_pos(k));
            cs_n = 1'b1;
            tick(6);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule